// File: doc/BRIEF.md
# Special Register Access Control Unit

This block serves move-to and move-from requests for a processor's special registers. Each request names a 10-bit register number. It says whether the access is a read or a write, and it carries write data and the current privilege level. The unit classifies the register number. It then either completes the access against a bank of 32-bit registers or refuses it with a program exception whose cause code tells an unimplemented number apart from a privilege violation.

Each implemented number has its own bit-level behaviour. Some bits are kept and some always read as zero. Some registers are constants. One group of status bits is set by hardware and can only be cleared by software. Another pair of bits reads live hardware status and ignores written zeros. Single flags are driven straight from hardware inputs. A window of eight numbers gives a read-only view of the performance-monitor registers.

Bit numbers in this brief count bit 0 as the most significant bit of the 32-bit word. Hex values are written in the usual way.

Top module: `spr_access_unit`

## Requirements
- R1: Numbers 0, 2-7, 10-17, 20, 21, 23, 24, 276-281, 283, 286, 944-951, 1011, 1012, 1014-1016, 1018 and 1023 are unimplemented. Any read or write to them, in either mode, raises an exception with cause 2'b01 (illegal).
- R2: When user_mode is 1, an access to any implemented number other than 1, 8 and 9 raises cause 2'b10 (privileged). Reads of 936-943 are the one exception to this rule. An unimplemented number reports 2'b01 even in user mode.
- R3: Numbers 8 and 9 keep all 32 bits. Number 1 keeps only the bits in 0xE000FF7F.
- R4: Writing all ones reads back as follows: number 25 gives 0xFFFF01FF, 282 gives 0x8000000F, 1010 gives 0xFFFFFFFE, 1019 gives 0x000001FF, 1020 and 1021 give 0x3F800007, and 1022 gives 0xFE003FFF. In 528-543, even numbers give 0xFFFE1FFF and odd numbers give 0xFFFE007B.
- R5: Number 287 always reads 0x00083214 and number 1009 always reads 0x80000000. Number 959 always reads 0. Writes to these three complete without fault and change nothing.
- R6: In number 920, bits 4-7 read as zero. Bits 8-11 are sticky flags. Input hw_flag_set[i] sets bit 11-i, which is mask 0x00100000 for i=0. A software write clears a sticky bit where the written bit is 0 and never sets one. Writing all ones from reset reads back 0xF00FFFFF.
- R7: In number 923, bits 30 and 31 read xfer_status[1] and xfer_status[0]. Writing them has no stored effect. With status 0, writing all ones reads back 0xFFFFFFFC.
- R8: Number 921 reads bits 27-30 as zero and bit 31 as pipe_busy, so all ones reads back as 0xFFFFFFE0 when idle. Number 1017 reads bits 24-30 as zero and bit 31 as inval_busy.
- R9: Numbers 936-943 read the same values as 952-959 in either mode. Writing them raises cause 2'b01 in either mode. Number 953 keeps only 0xFFC00000.
- R10: A faulting access changes no register and returns read data 0. A completed access reports cause 2'b00.
- R11: For each request, exactly one of done and exc_valid pulses, in the cycle after the request is sampled. Both stay low in cycles that follow no request. A completed write returns read data 0.
- R12: Reset clears every stored bit. After reset, reads of writable registers return zero.
- R13: Every implemented number has its own storage. Eight distinct values written to 912-919 all read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_num | input | 10 | Special register number |
| req_wdata | input | 32 | Write data |
| user_mode | input | 1 | Requester runs at user privilege |
| hw_flag_set | input | 4 | Hardware set pulses for the sticky flags of number 920 |
| pipe_busy | input | 1 | Pipe-not-empty status read in number 921 |
| xfer_status | input | 2 | Transfer status bits read in number 923 |
| inval_busy | input | 1 | Invalidation-in-progress status read in number 1017 |
| rd_data | output | 32 | Read result, zero for writes and faults |
| done | output | 1 | Access completed |
| exc_valid | output | 1 | Access refused with a program exception |
| exc_cause | output | 2 | 2'b01 illegal, 2'b10 privileged, 2'b00 otherwise |

## Verification
Every result is registered once. done, exc_valid, exc_cause and rd_data for a request sampled at one rising edge are therefore valid from that edge until the next. The bench drives each request at a falling edge, lets exactly one rising edge pass, and samples at the following falling edge. It then checks at the next falling edge that both pulses have dropped. Hardware status inputs feed read data in the request cycle, and the sticky set pulse is captured at its own edge. The bench sets these inputs a full cycle before the access that observes them.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int DATA_W = 32;
    localparam int NUM_W  = 10;
    localparam int SLOTS  = 64;
    localparam int SLOT_W = $clog2(SLOTS);

    localparam int SLOT_STICKY = 40;
    localparam int STICKY_LSB  = 20;
    localparam int STICKY_N    = 4;

    typedef enum logic [1:0] {
        CLS_ILLEGAL = 2'd0,
        CLS_USER    = 2'd1,
        CLS_PRIV    = 2'd2,
        CLS_MONITOR = 2'd3
    } acc_cls_e;

    typedef enum logic [2:0] {
        KIND_PLAIN  = 3'd0,
        KIND_CONST  = 3'd1,
        KIND_STICKY = 3'd2,
        KIND_PIPE   = 3'd3,
        KIND_XFER   = 3'd4,
        KIND_INVAL  = 3'd5
    } bit_kind_e;

    localparam logic [1:0] CAUSE_NONE    = 2'b00;
    localparam logic [1:0] CAUSE_ILLEGAL = 2'b01;
    localparam logic [1:0] CAUSE_PRIV    = 2'b10;

    typedef struct packed {
        acc_cls_e          cls;
        bit_kind_e         kind;
        logic [SLOT_W-1:0] slot;
        logic [DATA_W-1:0] keep;
        logic [DATA_W-1:0] konst;
    } spr_info_t;
endpackage

// File: rtl/spr_decode.sv
module spr_decode
    import spr_pkg::*;
(
    input  logic [NUM_W-1:0] num,
    output spr_info_t        info
);
    localparam logic [DATA_W-1:0] ONES = '1;

    function automatic spr_info_t mk(acc_cls_e c, bit_kind_e k, int s,
                                     logic [DATA_W-1:0] keep, logic [DATA_W-1:0] konst);
        spr_info_t r;
        r.cls   = c;
        r.kind  = k;
        r.slot  = SLOT_W'(s);
        r.keep  = keep;
        r.konst = konst;
        return r;
    endfunction

    logic             mon;
    logic [NUM_W-1:0] n;

    always_comb begin
        // the read-only monitor window aliases 952-959
        mon  = (num >= NUM_W'(936)) && (num <= NUM_W'(943));
        n    = mon ? num + NUM_W'(16) : num;
        info = mk(CLS_ILLEGAL, KIND_PLAIN, 0, '0, '0);
        case (n) inside
            NUM_W'(1):                 info = mk(CLS_USER, KIND_PLAIN, 0, 32'hE000FF7F, '0);
            NUM_W'(8):                 info = mk(CLS_USER, KIND_PLAIN, 1, ONES, '0);
            NUM_W'(9):                 info = mk(CLS_USER, KIND_PLAIN, 2, ONES, '0);
            NUM_W'(18):                info = mk(CLS_PRIV, KIND_PLAIN, 3, ONES, '0);
            NUM_W'(19):                info = mk(CLS_PRIV, KIND_PLAIN, 4, ONES, '0);
            NUM_W'(22):                info = mk(CLS_PRIV, KIND_PLAIN, 5, ONES, '0);
            NUM_W'(25):                info = mk(CLS_PRIV, KIND_PLAIN, 6, 32'hFFFF01FF, '0);
            NUM_W'(26):                info = mk(CLS_PRIV, KIND_PLAIN, 7, ONES, '0);
            NUM_W'(27):                info = mk(CLS_PRIV, KIND_PLAIN, 8, ONES, '0);
            [NUM_W'(272):NUM_W'(275)]: info = mk(CLS_PRIV, KIND_PLAIN, int'(n) - 263, ONES, '0);
            NUM_W'(282):               info = mk(CLS_PRIV, KIND_PLAIN, 13, 32'h8000000F, '0);
            NUM_W'(284):               info = mk(CLS_PRIV, KIND_PLAIN, 14, ONES, '0);
            NUM_W'(285):               info = mk(CLS_PRIV, KIND_PLAIN, 15, ONES, '0);
            NUM_W'(287):               info = mk(CLS_PRIV, KIND_CONST, 0, '0, 32'h00083214);
            [NUM_W'(528):NUM_W'(543)]: info = mk(CLS_PRIV, KIND_PLAIN, int'(n) - 512,
                                                 n[0] ? 32'hFFFE007B : 32'hFFFE1FFF, '0);
            [NUM_W'(912):NUM_W'(919)]: info = mk(CLS_PRIV, KIND_PLAIN, int'(n) - 880, ONES, '0);
            NUM_W'(920):               info = mk(CLS_PRIV, KIND_STICKY, SLOT_STICKY, 32'hF00FFFFF, '0);
            NUM_W'(921):               info = mk(CLS_PRIV, KIND_PIPE, 41, 32'hFFFFFFE0, '0);
            NUM_W'(922):               info = mk(CLS_PRIV, KIND_PLAIN, 42, ONES, '0);
            NUM_W'(923):               info = mk(CLS_PRIV, KIND_XFER, 43, 32'hFFFFFFFC, '0);
            NUM_W'(953):               info = mk(CLS_PRIV, KIND_PLAIN, 45, 32'hFFC00000, '0);
            NUM_W'(959):               info = mk(CLS_PRIV, KIND_CONST, 0, '0, '0);
            [NUM_W'(952):NUM_W'(958)]: info = mk(CLS_PRIV, KIND_PLAIN, 44 + int'(n[2:0]), ONES, '0);
            NUM_W'(1008):              info = mk(CLS_PRIV, KIND_PLAIN, 52, ONES, '0);
            NUM_W'(1009):              info = mk(CLS_PRIV, KIND_CONST, 0, '0, 32'h80000000);
            NUM_W'(1010):              info = mk(CLS_PRIV, KIND_PLAIN, 53, 32'hFFFFFFFE, '0);
            NUM_W'(1013):              info = mk(CLS_PRIV, KIND_PLAIN, 54, ONES, '0);
            NUM_W'(1017):              info = mk(CLS_PRIV, KIND_INVAL, 55, 32'hFFFFFF00, '0);
            NUM_W'(1019):              info = mk(CLS_PRIV, KIND_PLAIN, 56, 32'h000001FF, '0);
            NUM_W'(1020):              info = mk(CLS_PRIV, KIND_PLAIN, 57, 32'h3F800007, '0);
            NUM_W'(1021):              info = mk(CLS_PRIV, KIND_PLAIN, 58, 32'h3F800007, '0);
            NUM_W'(1022):              info = mk(CLS_PRIV, KIND_PLAIN, 59, 32'hFE003FFF, '0);
            default:                   ;
        endcase
        if (mon) info.cls = CLS_MONITOR;
    end
endmodule

// File: rtl/spr_merge.sv
module spr_merge
    import spr_pkg::*;
(
    input  bit_kind_e         kind,
    input  logic [DATA_W-1:0] keep,
    input  logic [DATA_W-1:0] konst,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pipe_busy,
    input  logic [1:0]        xfer_status,
    input  logic              inval_busy,
    output logic [DATA_W-1:0] wr_val,
    output logic [DATA_W-1:0] rd_val
);
    localparam logic [DATA_W-1:0] STK = DATA_W'({STICKY_N{1'b1}}) << STICKY_LSB;

    always_comb begin
        wr_val = wdata & keep;
        rd_val = old_val;
        case (kind)
            KIND_STICKY: wr_val = (wdata & keep & ~STK) | (old_val & wdata & STK);
            KIND_PIPE:   rd_val = old_val | DATA_W'(pipe_busy);
            KIND_XFER:   rd_val = old_val | DATA_W'(xfer_status);
            KIND_INVAL:  rd_val = old_val | DATA_W'(inval_busy);
            KIND_CONST:  rd_val = konst;
            default:     ;
        endcase
    end
endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
    import spr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [NUM_W-1:0]  req_num,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              user_mode,
    input  logic [STICKY_N-1:0] hw_flag_set,
    input  logic              pipe_busy,
    input  logic [1:0]        xfer_status,
    input  logic              inval_busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              exc_valid,
    output logic [1:0]        exc_cause
);
    typedef struct packed {
        logic [SLOTS-1:0][DATA_W-1:0] regs;
        logic [DATA_W-1:0]            rdata;
        logic                         done;
        logic                         exc;
        logic [1:0]                   cause;
    } state_t;

    state_t            st_d, st_q;
    spr_info_t         info;
    logic [DATA_W-1:0] wr_val, rd_val;

    spr_decode u_decode (
        .num  (req_num),
        .info (info)
    );

    spr_merge u_merge (
        .kind        (info.kind),
        .keep        (info.keep),
        .konst       (info.konst),
        .old_val     (st_q.regs[info.slot]),
        .wdata       (req_wdata),
        .pipe_busy   (pipe_busy),
        .xfer_status (xfer_status),
        .inval_busy  (inval_busy),
        .wr_val      (wr_val),
        .rd_val      (rd_val)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        st_d.done  = 1'b0;
        st_d.exc   = 1'b0;
        st_d.cause = CAUSE_NONE;
        if (req_valid) begin
            if (info.cls == CLS_ILLEGAL || (info.cls == CLS_MONITOR && req_write)) begin
                st_d.exc   = 1'b1;
                st_d.cause = CAUSE_ILLEGAL;
            end else if (info.cls == CLS_PRIV && user_mode) begin
                st_d.exc   = 1'b1;
                st_d.cause = CAUSE_PRIV;
            end else begin
                st_d.done = 1'b1;
                if (!req_write)
                    st_d.rdata = rd_val;
                else if (info.kind != KIND_CONST)
                    st_d.regs[info.slot] = wr_val;
            end
        end
        // hardware set wins over a software clear in the same cycle
        st_d.regs[SLOT_STICKY][STICKY_LSB +: STICKY_N] =
            st_d.regs[SLOT_STICKY][STICKY_LSB +: STICKY_N] | hw_flag_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.rdata;
    assign done      = st_q.done;
    assign exc_valid = st_q.exc;
    assign exc_cause = st_q.cause;

    logic [STICKY_N-1:0] sticky_q;
    assign sticky_q = st_q.regs[SLOT_STICKY][STICKY_LSB +: STICKY_N];

    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) |-> (done ^ exc_valid));
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!done && !exc_valid));
    a_r10_fault_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (rd_data == '0 && exc_cause != CAUSE_NONE));
    a_r10_done_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (exc_cause == CAUSE_NONE));
    a_r2_priv_needs_user: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_cause == CAUSE_PRIV) |-> $past(user_mode));
    a_r6_sticky_hw_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((sticky_q & ~$past(sticky_q)) != '0) |-> ($past(hw_flag_set) != '0));
    a_r5_version_const: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(req_write) && $past(req_num) == NUM_W'(287)) |-> (rd_data == 32'h00083214));
endmodule

// File: tb/spr_access_unit_bench.sv
module spr_access_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_num = '0;
    logic [31:0] req_wdata = '0;
    logic        user_mode = 1'b0;
    logic [3:0]  hw_flag_set = '0;
    logic        pipe_busy = 1'b0;
    logic [1:0]  xfer_status = '0;
    logic        inval_busy = 1'b0;
    logic [31:0] rd_data;
    logic        done, exc_valid;
    logic [1:0]  exc_cause;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spr_access_unit u_spr_access_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_num(req_num), .req_wdata(req_wdata), .user_mode(user_mode),
        .hw_flag_set(hw_flag_set), .pipe_busy(pipe_busy), .xfer_status(xfer_status),
        .inval_busy(inval_busy), .rd_data(rd_data), .done(done),
        .exc_valid(exc_valid), .exc_cause(exc_cause)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, one rising edge captures, sample at the next falling edge
    task automatic access(bit wr, int num, logic [31:0] d, bit usr);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_num = 10'(num);
        req_wdata = d; user_mode = usr;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0; user_mode = 1'b0;
    endtask

    task automatic wr_ok(int num, logic [31:0] d, bit usr, string tag);
        access(1'b1, num, d, usr);
        chk({tag, " write done"}, 32'(done), 32'd1);
        chk({tag, " write data zero"}, rd_data, 32'd0);
    endtask

    task automatic rd_expect(int num, bit usr, logic [31:0] exp, string tag);
        access(1'b0, num, '0, usr);
        chk({tag, " read done"}, {30'd0, exc_cause, done, exc_valid} , 32'd2);
        chk({tag, " read data"}, rd_data, exp);
    endtask

    task automatic fault_expect(bit wr, int num, bit usr, logic [1:0] cause, string tag);
        access(wr, num, 32'hFFFFFFFF, usr);
        chk({tag, " exc"}, {29'd0, done, exc_valid, 1'b0}, 32'd2);
        chk({tag, " cause"}, 32'(exc_cause), 32'(cause));
        chk({tag, " data"}, rd_data, 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("R12 done after reset", 32'(done), 0);
        chk("R12 exc after reset", 32'(exc_valid), 0);
        chk("R12 data after reset", rd_data, 0);
        rd_expect(8, 1'b0, 32'd0, "R12 reg8 reset");
        rd_expect(920, 1'b0, 32'd0, "R12 reg920 reset");
        wr_ok(9, 32'h12345678, 1'b0, "R12 pre");
        do_reset();
        rd_expect(9, 1'b0, 32'd0, "R12 reg9 cleared by reset");
    endtask

    task automatic t_illegal();
        int nums[8] = '{0, 5, 16, 283, 286, 947, 1018, 1023};
        foreach (nums[i]) begin
            fault_expect(1'b0, nums[i], 1'b0, 2'b01, $sformatf("R1 read %0d sup", nums[i]));
            fault_expect(1'b1, nums[i], 1'b1, 2'b01, $sformatf("R1 write %0d usr", nums[i]));
        end
    endtask

    task automatic t_user();
        wr_ok(26, 32'hCAFEF00D, 1'b0, "R2 setup");
        fault_expect(1'b0, 26, 1'b1, 2'b10, "R2 user read 26");
        fault_expect(1'b1, 26, 1'b1, 2'b10, "R2 user write 26");
        fault_expect(1'b0, 920, 1'b1, 2'b10, "R2 user read 920");
        fault_expect(1'b0, 287, 1'b1, 2'b10, "R2 user read 287");
        rd_expect(26, 1'b0, 32'hCAFEF00D, "R10 faulting write left 26");
        wr_ok(1, 32'hFFFFFFFF, 1'b1, "R2 user reg1");
        rd_expect(1, 1'b1, 32'hE000FF7F, "R3 reg1 mask");
        wr_ok(8, 32'hFFFFFFFF, 1'b1, "R2 user reg8");
        rd_expect(8, 1'b1, 32'hFFFFFFFF, "R3 reg8 full");
        wr_ok(9, 32'hDEADBEEF, 1'b1, "R2 user reg9");
        rd_expect(9, 1'b1, 32'hDEADBEEF, "R3 reg9 full");
        wr_ok(1, 32'h00000000, 1'b0, "R3 reg1 clear");
        rd_expect(1, 1'b0, 32'h0, "R3 reg1 zero");
    endtask

    task automatic t_masks();
        int nums[9] = '{25, 282, 1010, 1019, 1020, 1021, 1022, 530, 531};
        logic [31:0] exps[9] = '{32'hFFFF01FF, 32'h8000000F, 32'hFFFFFFFE, 32'h000001FF,
                                 32'h3F800007, 32'h3F800007, 32'hFE003FFF,
                                 32'hFFFE1FFF, 32'hFFFE007B};
        foreach (nums[i]) begin
            wr_ok(nums[i], 32'hFFFFFFFF, 1'b0, $sformatf("R4 %0d", nums[i]));
            rd_expect(nums[i], 1'b0, exps[i], $sformatf("R4 %0d readback", nums[i]));
        end
    endtask

    task automatic t_const();
        wr_ok(287, 32'hFFFFFFFF, 1'b0, "R5 287");
        rd_expect(287, 1'b0, 32'h00083214, "R5 287 const");
        wr_ok(1009, 32'hFFFFFFFF, 1'b0, "R5 1009");
        rd_expect(1009, 1'b0, 32'h80000000, "R5 1009 const");
        wr_ok(959, 32'hFFFFFFFF, 1'b0, "R5 959");
        rd_expect(959, 1'b0, 32'h0, "R5 959 const");
    endtask

    task automatic t_sticky();
        wr_ok(920, 32'hFFFFFFFF, 1'b0, "R6 ones");
        rd_expect(920, 1'b0, 32'hF00FFFFF, "R6 ones readback");
        @(negedge clk); hw_flag_set = 4'b0001;
        @(negedge clk); hw_flag_set = 4'b0000;
        rd_expect(920, 1'b0, 32'hF01FFFFF, "R6 hw set bit 11");
        wr_ok(920, 32'hFFFFFFFF, 1'b0, "R6 ones keep");
        rd_expect(920, 1'b0, 32'hF01FFFFF, "R6 flag kept");
        wr_ok(920, 32'hF00FFFFF, 1'b0, "R6 clear");
        rd_expect(920, 1'b0, 32'hF00FFFFF, "R6 flag cleared");
    endtask

    task automatic t_status();
        wr_ok(923, 32'hFFFFFFFF, 1'b0, "R7 ones");
        rd_expect(923, 1'b0, 32'hFFFFFFFC, "R7 idle readback");
        xfer_status = 2'b11;
        rd_expect(923, 1'b0, 32'hFFFFFFFF, "R7 status shown");
        wr_ok(923, 32'h0, 1'b0, "R7 zero");
        rd_expect(923, 1'b0, 32'h00000003, "R7 zero write keeps status");
        xfer_status = 2'b00;
        wr_ok(921, 32'hFFFFFFFF, 1'b0, "R8 921");
        rd_expect(921, 1'b0, 32'hFFFFFFE0, "R8 921 idle");
        pipe_busy = 1'b1;
        rd_expect(921, 1'b0, 32'hFFFFFFE1, "R8 921 busy");
        pipe_busy = 1'b0;
        wr_ok(1017, 32'hFFFFFFFF, 1'b0, "R8 1017");
        rd_expect(1017, 1'b0, 32'hFFFFFF00, "R8 1017 idle");
        inval_busy = 1'b1;
        rd_expect(1017, 1'b0, 32'hFFFFFF01, "R8 1017 busy");
        inval_busy = 1'b0;
    endtask

    task automatic t_monitor();
        wr_ok(953, 32'hFFFFFFFF, 1'b0, "R9 953");
        rd_expect(953, 1'b0, 32'hFFC00000, "R9 953 mask");
        rd_expect(937, 1'b1, 32'hFFC00000, "R9 937 user view");
        wr_ok(952, 32'hA5A5A5A5, 1'b0, "R9 952");
        rd_expect(936, 1'b0, 32'hA5A5A5A5, "R9 936 sup view");
        rd_expect(943, 1'b1, 32'h0, "R9 943 view");
        fault_expect(1'b1, 936, 1'b0, 2'b01, "R9 write 936 sup");
        fault_expect(1'b1, 940, 1'b1, 2'b01, "R9 write 940 usr");
        rd_expect(952, 1'b0, 32'hA5A5A5A5, "R10 952 untouched");
        fault_expect(1'b0, 952, 1'b1, 2'b10, "R2 user read 952");
    endtask

    task automatic t_timing();
        access(1'b0, 8, '0, 1'b0);
        chk("R11 done pulse", 32'(done), 1);
        @(negedge clk);
        chk("R11 done drops", 32'(done), 0);
        chk("R11 exc idle", 32'(exc_valid), 0);
        access(1'b0, 2, '0, 1'b0);
        chk("R11 exc pulse", 32'(exc_valid), 1);
        @(negedge clk);
        chk("R11 exc drops", 32'(exc_valid), 0);
        chk("R11 cause idle", 32'(exc_cause), 0);
    endtask

    task automatic t_banks();
        for (int i = 0; i < 8; i++)
            wr_ok(912 + i, {8{4'(i + 1)}}, 1'b0, "R13 gqr write");
        for (int i = 0; i < 8; i++)
            rd_expect(912 + i, 1'b0, {8{4'(i + 1)}}, $sformatf("R13 gqr %0d", i));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_illegal();
        t_user();
        t_masks();
        t_const();
        t_sticky();
        t_status();
        t_monitor();
        t_timing();
        t_banks();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule